// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block puts a small word-addressed memory behind several requester ports and tracks one address reservation per requester. Each requester can read, write, load-linked or store-conditional. A load-linked returns the stored word and reserves its address for that requester. A later store-conditional writes only while the reservation is intact. It answers 1 when the write happened and 0 when it did not. Software spins on the answer and retries on zero, which is enough to build locks and counters on the shared array without any other atomic operation.

A fixed-priority arbiter serves one request per cycle, and the lowest-numbered requester goes first. A requester holds its request until its ready bit is high. The answer returns one cycle later on a shared data bus, with a per-requester valid bit. Any write that reaches the array knocks out the matching reservations held by the other requesters, in the same cycle as the write.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no response is valid, no requester holds a reservation, and every memory word reads as zero.
- R2: Among the requesters with `req_valid` set, only the lowest-numbered one sees `req_ready` high, in the same cycle. At most one ready bit is high per cycle.
- R3: One cycle after a grant, `rsp_valid` of that requester is high. `req_op` is encoded as 00 read, 01 store, 10 load-linked and 11 store-conditional. Read and load-linked return the addressed word on `rsp_data`, and a store returns zero.
- R4: A load-linked records a reservation on its address for the issuing requester. A newer load-linked replaces any earlier one, so a store-conditional to the old address fails.
- R5: A store-conditional whose address matches the requester's live reservation writes its data to memory and returns 1.
- R6: A store-conditional with no reservation, or with an address other than the reserved one, returns 0 and leaves memory unchanged.
- R7: A store-conditional clears the issuing requester's reservation whether it succeeds or fails.
- R8: A plain store, or a successful store-conditional, clears every other requester's reservation on the same address. A requester's own plain store does not clear its own reservation, and a store to a different address clears nothing.
- R9: When two requesters with reservations on the same address issue a store-conditional in the same cycle, the higher-priority one succeeds and the other then fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NREQ | Per-requester request present |
| req_op | input | 2*NREQ | Per-requester operation code, 2 bits each |
| req_addr | input | NREQ*AW | Per-requester word address |
| req_wdata | input | NREQ*DW | Per-requester store data |
| req_ready | output | NREQ | Grant: request accepted this cycle |
| rsp_valid | output | NREQ | Response present for the requester granted last cycle |
| rsp_data | output | DW | Read data, zero for a store, or the 1/0 store-conditional result |

## Verification
The hardest case to reach is two store-conditionals to one reserved address in the same cycle. One must win and the other must lose, because the winner's write clears the loser's reservation while the loser waits for its grant. The bench first gives requesters 1 and 2 reservations on the same word. It then drives both store-conditionals on the same falling edge. It checks that only requester 1 is ready and that it answers 1. Requester 2 is granted next and must answer 0, and the word must hold requester 1's data.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NREQ  = 4,
  parameter int DEPTH = 16,
  parameter int DW    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREQ-1:0]               req_valid,
  input  logic [2*NREQ-1:0]             req_op,
  input  logic [NREQ*$clog2(DEPTH)-1:0] req_addr,
  input  logic [NREQ*DW-1:0]            req_wdata,
  output logic [NREQ-1:0]               req_ready,
  output logic [NREQ-1:0]               rsp_valid,
  output logic [DW-1:0]                 rsp_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam logic [1:0] OP_RD = 2'b00;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_LL = 2'b10;
  localparam logic [1:0] OP_SC = 2'b11;

  logic [DW-1:0] mem [DEPTH];
  logic [NREQ-1:0] resv_vld;
  logic [AW-1:0]   resv_addr [NREQ];

  logic [IW-1:0] gidx;
  logic          any_req;
  logic [1:0]    g_op;
  logic [AW-1:0] g_addr;
  logic [DW-1:0] g_wdata;
  logic          sc_hit, do_write;

  always_comb begin
    gidx = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (req_valid[i]) gidx = IW'(i);
  end

  assign any_req   = |req_valid;
  assign req_ready = any_req ? (NREQ'(1) << gidx) : '0;
  assign g_op      = req_op[int'(gidx)*2 +: 2];
  assign g_addr    = req_addr[int'(gidx)*AW +: AW];
  assign g_wdata   = req_wdata[int'(gidx)*DW +: DW];
  assign sc_hit    = resv_vld[gidx] && (resv_addr[gidx] == g_addr);
  assign do_write  = any_req && (g_op == OP_WR || (g_op == OP_SC && sc_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++) mem[d] <= '0;
    end else if (do_write) begin
      mem[g_addr] <= g_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_vld <= '0;
      for (int i = 0; i < NREQ; i++) resv_addr[i] <= '0;
    end else begin
      for (int i = 0; i < NREQ; i++) begin
        if (req_ready[i] && g_op == OP_LL) begin
          resv_vld[i]  <= 1'b1;
          resv_addr[i] <= g_addr;
        end else if (req_ready[i] && g_op == OP_SC) begin
          resv_vld[i] <= 1'b0;
        end else if (do_write && !req_ready[i] && resv_addr[i] == g_addr) begin
          resv_vld[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_ready;
      if (any_req) begin
        unique case (g_op)
          OP_RD, OP_LL: rsp_data <= mem[g_addr];
          OP_WR:        rsp_data <= '0;
          OP_SC:        rsp_data <= DW'(sc_hit);
        endcase
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R2
  AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[0] |-> req_ready[0]); // R2
  AST_SC_NO_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && g_op == OP_SC && !resv_vld[gidx]) |=> (rsp_data == '0)); // R6

  for (genvar i = 0; i < NREQ; i++) begin : g_chk
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[i] |=> rsp_valid[i]); // R3
    AST_LL_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready[i] && req_op[2*i +: 2] == OP_LL) |=>
        (resv_vld[i] && resv_addr[i] == $past(req_addr[i*AW +: AW]))); // R4
    AST_SC_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready[i] && req_op[2*i +: 2] == OP_SC) |=> !resv_vld[i]); // R7
  end
endmodule

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
  localparam int N = 4, D = 16, DW = 32, AW = 4;
  localparam logic [1:0] RD = 2'b00, WR = 2'b01, LL = 2'b10, SC = 2'b11;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_valid = '0;
  logic [2*N-1:0] req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0] req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  int checks = 0, fails = 0;
  bit done = 0;

  llsc_monitor uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input int i, input logic [1:0] op, input int a, input logic [31:0] d);
    req_valid[i] = 1'b1;
    req_op[i*2 +: 2] = op;
    req_addr[i*AW +: AW] = AW'(a);
    req_wdata[i*DW +: DW] = d;
  endtask

  task automatic issue(input int i, input logic [1:0] op, input int a, input logic [31:0] d,
                       output logic [31:0] rd);
    @(negedge clk);
    drive(i, op, a, d);
    #1;
    while (!req_ready[i]) begin @(negedge clk); #1; end
    @(negedge clk);
    check("R3 latency", 32'(rsp_valid[i]), 1);
    rd = rsp_data;
    req_valid[i] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] rd;
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 ready idle", 32'(req_ready), 0);
    issue(3, RD, 5, 0, rd); check("R1 mem zero", rd, 0);
    issue(2, SC, 5, 32'h77, rd); check("R1 no reservation", rd, 0);
  endtask

  task automatic t_plain;
    logic [31:0] rd;
    issue(0, WR, 3, 32'hA5A5_0003, rd); check("R3 store returns 0", rd, 0);
    issue(3, RD, 3, 0, rd); check("R3 read data", rd, 32'hA5A5_0003);
  endtask

  task automatic t_ll_sc;
    logic [31:0] rd;
    issue(0, WR, 4, 32'h44, rd);
    issue(1, LL, 4, 0, rd); check("R3 LL data", rd, 32'h44);
    issue(1, SC, 4, 32'hBEEF, rd); check("R5 SC success", rd, 1);
    issue(0, RD, 4, 0, rd); check("R5 SC wrote", rd, 32'hBEEF);
    issue(1, SC, 4, 32'h1111, rd); check("R7 second SC fails", rd, 0);
    issue(0, RD, 4, 0, rd); check("R7 no write", rd, 32'hBEEF);
  endtask

  task automatic t_sc_fail;
    logic [31:0] rd;
    issue(2, SC, 6, 32'h66, rd); check("R6 no reservation", rd, 0);
    issue(0, RD, 6, 0, rd); check("R6 mem unchanged", rd, 0);
    issue(2, LL, 6, 0, rd);
    issue(2, SC, 7, 32'h77, rd); check("R6 wrong address", rd, 0);
    issue(0, RD, 7, 0, rd); check("R6 no write wrong addr", rd, 0);
    issue(2, SC, 6, 32'h66, rd); check("R7 cleared by failed SC", rd, 0);
  endtask

  task automatic t_replace;
    logic [31:0] rd;
    issue(3, LL, 9, 0, rd);
    issue(3, LL, 10, 0, rd);
    issue(3, SC, 9, 32'h99, rd); check("R4 old reservation gone", rd, 0);
    issue(0, RD, 9, 0, rd); check("R4 no write", rd, 0);
    issue(3, LL, 10, 0, rd);
    issue(3, SC, 10, 32'hAA, rd); check("R4 new reservation", rd, 1);
  endtask

  task automatic t_other_store;
    logic [31:0] rd;
    issue(2, LL, 11, 0, rd);
    issue(0, WR, 11, 32'h1, rd);
    issue(2, SC, 11, 32'h2, rd); check("R8 foreign store clears", rd, 0);
    issue(2, LL, 12, 0, rd);
    issue(0, WR, 13, 32'h3, rd);
    issue(2, SC, 12, 32'h4, rd); check("R8 other address keeps", rd, 1);
    issue(2, LL, 14, 0, rd);
    issue(2, WR, 14, 32'h5, rd);
    issue(2, SC, 14, 32'h6, rd); check("R8 own store keeps", rd, 1);
    issue(1, LL, 15, 0, rd);
    issue(3, LL, 15, 0, rd);
    issue(3, SC, 15, 32'h7, rd); check("R8 SC by r3 ok", rd, 1);
    issue(1, SC, 15, 32'h8, rd); check("R8 foreign SC clears", rd, 0);
    issue(0, RD, 15, 0, rd); check("R8 value", rd, 32'h7);
  endtask

  task automatic t_race;
    logic [31:0] rd;
    issue(1, LL, 2, 0, rd);
    issue(2, LL, 2, 0, rd);
    @(negedge clk);
    drive(1, SC, 2, 32'h1001);
    drive(2, SC, 2, 32'h2002);
    #1; check("R2 priority grant", 32'(req_ready), 32'b0010);
    @(negedge clk);
    check("R9 winner", rsp_data, 1);
    req_valid[1] = 1'b0;
    #1; check("R2 next grant", 32'(req_ready), 32'b0100);
    @(negedge clk);
    check("R3 loser rsp", 32'(rsp_valid), 32'b0100);
    check("R9 loser", rsp_data, 0);
    req_valid[2] = 1'b0;
    issue(0, RD, 2, 0, rd); check("R9 memory", rd, 32'h1001);
    @(negedge clk);
    drive(3, RD, 0, 0); drive(0, RD, 1, 0);
    #1; check("R2 r0 over r3", 32'(req_ready), 32'b0001);
    @(negedge clk); req_valid[0] = 1'b0;
    @(negedge clk); req_valid[3] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_plain();
    t_ll_sc();
    t_sc_fail();
    t_replace();
    t_other_store();
    t_race();
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule